// File: doc/BRIEF.md
# Ten-Operation 32-Bit Integer ALU

The block computes one integer operation per clock on two 32-bit operands chosen by a 4-bit mode code: signed and unsigned addition and subtraction, the four bitwise functions AND, OR, XOR and NOR, and signed and unsigned less-than comparison. Operands are expected already prepared by the caller, so immediate forms, sign extension, shifts, multiply and divide are handled elsewhere in the datapath.

The arithmetic core is a single adder that also serves subtraction and both comparisons. For subtraction the B operand is inverted and the low carry-in is forced to 1. The adder forms carries with per-group generate/propagate lookahead. The computed result, carry and overflow are captured in output registers on the rising clock edge, so each answer appears one cycle after its operands.

Top module: `int_alu`

## Requirements
- R1: Outputs are registered. Operands and mode sampled at one rising edge appear on `res_q`, `carry_q` and `ovf_q` right after that edge. A synchronous active-high `rst` clears all three outputs to 0.
- R2: Mode 4'h0 (signed add) and 4'h1 (unsigned add) give `res_q` = (A + B) mod 2^32.
- R3: Mode 4'h2 (signed subtract) and 4'h3 (unsigned subtract) give `res_q` = A + ~B + 1 mod 2^32, which equals A − B mod 2^32.
- R4: In modes 4'h0 to 4'h3, `carry_q` is the carry out of bit 31 of the adder. For subtraction, 1 means no borrow occurred. In every other mode `carry_q` is 0.
- R5: In modes 4'h0 and 4'h2, `ovf_q` is the carry into bit 31 XOR the carry out of bit 31. It is 1 exactly when the signed result cannot be represented.
- R6: Modes 4'h1 and 4'h3 never set `ovf_q`.
- R7: Mode 4'h4 gives A&B, 4'h5 gives A|B, 4'h6 gives A^B and 4'h7 gives ~(A|B). In these modes carry and overflow are both 0.
- R8: Mode 4'hA puts a 1 in bit 0 exactly when A < B as signed two's-complement values, even when A − B overflows. Bits 31:1 are 0, and carry and overflow are 0.
- R9: Mode 4'hB puts a 1 in bit 0 exactly when A < B as unsigned values, which is when the subtraction borrows. Bits 31:1 are 0, and carry and overflow are 0.
- R10: Mode codes 4'h8, 4'h9 and 4'hC to 4'hF give a result of 0 with carry and overflow both 0.
- R11: A signed add of two operands whose sign bits differ never sets `ovf_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_mode | input | 4 | Operation select code |
| res_q | output | 32 | Registered result |
| carry_q | output | 1 | Registered bit-31 carry out |
| ovf_q | output | 1 | Registered signed overflow |

## Verification
The only state is the output register, so a fault surfaces at the ports one cycle after the operands that expose it. A wrong group carry corrupts the high bits of sums whose carries cross that group boundary. It also flips `carry_q` when it reaches bit 31. A misrouted bit-31 carry shows only on boundary operands: it gives a wrong overflow, and through the signed comparison a wrong less-than bit in bit 0. For this reason the directed tests aim at the signed limits 32'h7FFFFFFF and 32'h80000000.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_ADD  = 4'h0,
    MD_ADDU = 4'h1,
    MD_SUB  = 4'h2,
    MD_SUBU = 4'h3,
    MD_AND  = 4'h4,
    MD_OR   = 4'h5,
    MD_XOR  = 4'h6,
    MD_NOR  = 4'h7,
    MD_SLT  = 4'hA,
    MD_SLTU = 4'hB
  } alu_mode_e;

  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2,
    BW_NOR = 2'd3
  } bitwise_op_e;

  typedef struct packed {
    logic        arith;      // result and carry come from the adder
    logic        invert_b;   // subtract: ~B and carry-in 1
    logic        signed_ovf; // overflow may be flagged
    logic        cmp_signed; // signed less-than
    logic        cmp_unsig;  // unsigned less-than
    logic        bitwise;    // result from the logic unit
    bitwise_op_e bw_op;
  } alu_ctrl_t;

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
  import int_alu_pkg::*;
#(
  parameter int unsigned MW = MODE_W
) (
  input  logic [MW-1:0] mode,
  output alu_ctrl_t     ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.bw_op = BW_AND;
    case (mode)
      MD_ADD:  begin ctrl.arith = 1'b1; ctrl.signed_ovf = 1'b1; end
      MD_ADDU: begin ctrl.arith = 1'b1; end
      MD_SUB:  begin ctrl.arith = 1'b1; ctrl.invert_b = 1'b1; ctrl.signed_ovf = 1'b1; end
      MD_SUBU: begin ctrl.arith = 1'b1; ctrl.invert_b = 1'b1; end
      MD_AND:  begin ctrl.bitwise = 1'b1; ctrl.bw_op = BW_AND; end
      MD_OR:   begin ctrl.bitwise = 1'b1; ctrl.bw_op = BW_OR;  end
      MD_XOR:  begin ctrl.bitwise = 1'b1; ctrl.bw_op = BW_XOR; end
      MD_NOR:  begin ctrl.bitwise = 1'b1; ctrl.bw_op = BW_NOR; end
      MD_SLT:  begin ctrl.invert_b = 1'b1; ctrl.cmp_signed = 1'b1; end
      MD_SLTU: begin ctrl.invert_b = 1'b1; ctrl.cmp_unsig = 1'b1; end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/int_alu_cla.sv
module int_alu_cla #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned GROUP = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             c_into_msb
);

  localparam int unsigned NGRP = WIDTH / GROUP;

  logic [WIDTH-1:0] gen_b;
  logic [WIDTH-1:0] prop_b;
  logic [WIDTH-1:0] bit_cin;
  logic [NGRP:0]    grp_c;

  assign gen_b  = a & b;
  assign prop_b = a ^ b;
  assign grp_c[0] = cin;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    localparam int unsigned BASE = k * GROUP;
    logic [GROUP:0] loc_c;
    logic           grp_g;
    logic           grp_p;

    // group generate / propagate: carry jumps over the group in one step
    always_comb begin
      grp_g = 1'b0;
      grp_p = 1'b1;
      for (int j = 0; j < int'(GROUP); j++) begin
        grp_g = gen_b[BASE+j] | (prop_b[BASE+j] & grp_g);
        grp_p = grp_p & prop_b[BASE+j];
      end
    end

    // per-bit carries inside the group, seeded by the group carry-in
    always_comb begin
      loc_c[0] = grp_c[k];
      for (int j = 0; j < int'(GROUP); j++) begin
        loc_c[j+1] = gen_b[BASE+j] | (prop_b[BASE+j] & loc_c[j]);
      end
    end

    assign grp_c[k+1] = grp_g | (grp_p & grp_c[k]);
    assign bit_cin[BASE +: GROUP] = loc_c[GROUP-1:0];
  end

  assign sum        = prop_b ^ bit_cin;
  assign cout       = grp_c[NGRP];
  assign c_into_msb = bit_cin[WIDTH-1];

endmodule

// File: rtl/int_alu_bitwise.sv
module int_alu_bitwise
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  bitwise_op_e      op,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    case (op)
      BW_AND:  y = a & b;
      BW_OR:   y = a | b;
      BW_XOR:  y = a ^ b;
      default: y = ~(a | b);
    endcase
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W,
  parameter int unsigned CLA_GROUP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       op_mode,
  output logic [WIDTH-1:0] res_q,
  output logic             carry_q,
  output logic             ovf_q
);

  localparam int unsigned MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] add_sum;
  logic             add_cout;
  logic             add_cmsb;
  logic             raw_ovf;
  logic             lt_signed;
  logic             lt_unsig;
  logic [WIDTH-1:0] bw_y;
  logic [WIDTH-1:0] res_d;
  logic             carry_d;
  logic             ovf_d;

  int_alu_decode #(.MW(4)) u_decode (
    .mode (op_mode),
    .ctrl (ctrl)
  );

  assign b_eff = ctrl.invert_b ? ~op_b : op_b;

  int_alu_cla #(.WIDTH(WIDTH), .GROUP(CLA_GROUP)) u_adder (
    .a          (op_a),
    .b          (b_eff),
    .cin        (ctrl.invert_b),
    .sum        (add_sum),
    .cout       (add_cout),
    .c_into_msb (add_cmsb)
  );

  int_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a  (op_a),
    .b  (op_b),
    .op (ctrl.bw_op),
    .y  (bw_y)
  );

  assign raw_ovf   = add_cmsb ^ add_cout;
  assign lt_signed = add_sum[MSB] ^ raw_ovf;
  assign lt_unsig  = ~add_cout;

  always_comb begin
    res_d = '0;
    if (ctrl.arith)           res_d = add_sum;
    else if (ctrl.bitwise)    res_d = bw_y;
    else if (ctrl.cmp_signed) res_d = {{(WIDTH-1){1'b0}}, lt_signed};
    else if (ctrl.cmp_unsig)  res_d = {{(WIDTH-1){1'b0}}, lt_unsig};
  end

  assign carry_d = ctrl.arith & add_cout;
  assign ovf_d   = ctrl.arith & ctrl.signed_ovf & raw_ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      res_q   <= res_d;
      carry_q <= carry_d;
      ovf_q   <= ovf_d;
    end
  end

  AST_UNSIGNED_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_mode) == 4'h1 || $past(op_mode) == 4'h3)) |-> !ovf_q); // R6

  AST_BITWISE_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_mode[3:2]) == 2'b01) |-> (!carry_q && !ovf_q)); // R7

  AST_CMP_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_mode) == 4'hA || $past(op_mode) == 4'hB))
      |-> (res_q[MSB:1] == '0 && !carry_q && !ovf_q)); // R8

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_mode) == 4'h8 || $past(op_mode) == 4'h9 || $past(op_mode) >= 4'hC))
      |-> (res_q == '0 && !carry_q && !ovf_q)); // R10

  AST_OPPOSITE_SIGN_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_mode) == 4'h0 && ($past(op_a[MSB]) != $past(op_b[MSB]))) |-> !ovf_q); // R11

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (res_q == '0 && !carry_q && !ovf_q)); // R1

endmodule

// File: tb/int_alu_bench.sv
`timescale 1ns/1ps
module int_alu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [3:0]  op_mode = '0;
  logic [31:0] res_q;
  logic        carry_q;
  logic        ovf_q;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  int_alu u_int_alu (
    .clk     (clk),
    .rst     (rst),
    .op_a    (op_a),
    .op_b    (op_b),
    .op_mode (op_mode),
    .res_q   (res_q),
    .carry_q (carry_q),
    .ovf_q   (ovf_q)
  );

  // reference model written from the requirements
  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [3:0] m,
                       output logic [31:0] r, output logic c, output logic v);
    logic [32:0] w;
    r = '0; c = 1'b0; v = 1'b0;
    case (m)
      4'h0, 4'h1: begin
        w = {1'b0, a} + {1'b0, b};
        r = w[31:0]; c = w[32];
        if (m == 4'h0) v = (a[31] == b[31]) && (r[31] != a[31]);
      end
      4'h2, 4'h3: begin
        w = {1'b0, a} + {1'b0, ~b} + 33'd1;
        r = w[31:0]; c = w[32];
        if (m == 4'h2) v = (a[31] != b[31]) && (r[31] != a[31]);
      end
      4'h4: r = a & b;
      4'h5: r = a | b;
      4'h6: r = a ^ b;
      4'h7: r = ~(a | b);
      4'hA: r = {31'd0, ($signed(a) < $signed(b))};
      4'hB: r = {31'd0, (a < b)};
      default: ;
    endcase
  endtask

  task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                        input logic [3:0] m);
    logic [31:0] er; logic ec; logic ev;
    @(negedge clk);
    op_a = a; op_b = b; op_mode = m;
    @(posedge clk);
    #1;
    model(a, b, m, er, ec, ev);
    total++;
    if (res_q !== er || carry_q !== ec || ovf_q !== ev) begin
      bad++;
      $display("FAIL %s mode=%h a=%h b=%h actual res=%h c=%b v=%b expected res=%h c=%b v=%b",
               tag, m, a, b, res_q, carry_q, ovf_q, er, ec, ev);
    end
  endtask

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic t_reset();  // R1
    @(negedge clk);
    rst = 1'b1; op_a = 32'hFFFFFFFF; op_b = 32'h1; op_mode = 4'h0;
    @(posedge clk);
    #1;
    total++;
    if (res_q !== 32'd0 || carry_q !== 1'b0 || ovf_q !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset actual res=%h c=%b v=%b expected res=0 c=0 v=0", res_q, carry_q, ovf_q);
    end
    @(negedge clk);
    rst = 1'b0;
    // one-cycle latency: a value applied now shows right after this edge
    run_op("R1 latency", 32'd5, 32'd7, 4'h1);
  endtask

  task automatic t_add();
    run_op("R2 add small", 32'd7, 32'd3, 4'h0);
    run_op("R2 addu wrap R4 carry", 32'hFFFFFFFF, 32'd1, 4'h1);
    run_op("R2 add neg", 32'hFFFFFFFC, 32'hFFFFFFFB, 4'h0);
    run_op("R11 add opposite", 32'h80000000, 32'h7FFFFFFF, 4'h0);
    run_op("R11 add opposite2", 32'h7FFFFFFF, 32'hFFFFFFFF, 4'h0);
  endtask

  task automatic t_sub();
    run_op("R3 sub", 32'd10, 32'd3, 4'h2);
    run_op("R3 sub equal R4 carry", 32'h12345678, 32'h12345678, 4'h2);
    run_op("R3 subu borrow R4", 32'd3, 32'd10, 4'h3);
    run_op("R3 sub zero minus one", 32'd0, 32'd1, 4'h2);
  endtask

  task automatic t_overflow();
    run_op("R5 add pos ovf", 32'h7FFFFFFF, 32'd1, 4'h0);
    run_op("R5 add neg ovf", 32'h80000000, 32'hFFFFFFFF, 4'h0);
    run_op("R5 sub ovf low", 32'h80000000, 32'd1, 4'h2);
    run_op("R5 sub ovf high", 32'd0, 32'h80000000, 4'h2);
    run_op("R6 addu no ovf", 32'h7FFFFFFF, 32'd1, 4'h1);
    run_op("R6 subu no ovf", 32'h80000000, 32'd1, 4'h3);
  endtask

  task automatic t_bitwise();
    run_op("R7 and", 32'hF0F0A5A5, 32'hFF00FFFF, 4'h4);
    run_op("R7 or", 32'hF0F0A5A5, 32'h0F000000, 4'h5);
    run_op("R7 xor", 32'hFFFFFFFF, 32'h12345678, 4'h6);
    run_op("R7 nor", 32'h00FF0000, 32'h0000FF00, 4'h7);
  endtask

  task automatic t_slt();
    run_op("R8 slt neg<pos", 32'hFFFFFFFF, 32'd1, 4'hA);
    run_op("R8 slt ovf true", 32'h80000000, 32'd1, 4'hA);
    run_op("R8 slt ovf false", 32'h7FFFFFFF, 32'hFFFFFFFF, 4'hA);
    run_op("R8 slt equal", 32'd9, 32'd9, 4'hA);
    run_op("R9 sltu big", 32'hFFFFFFFF, 32'd1, 4'hB);
    run_op("R9 sltu less", 32'd1, 32'hFFFFFFFF, 4'hB);
    run_op("R9 sltu equal", 32'h80000000, 32'h80000000, 4'hB);
  endtask

  task automatic t_unused();
    logic [3:0] codes [6] = '{4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF};
    for (int i = 0; i < 6; i++) run_op("R10 unused", 32'hFFFFFFFF, 32'hFFFFFFFF, codes[i]);
  endtask

  task automatic t_sweep();
    logic [31:0] s = 32'hACE1BEEF;
    logic [3:0] md [10] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB};
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a; logic [31:0] b;
      s = xs(s); a = s;
      s = xs(s); b = s;
      run_op("R2 R3 R4 R5 R7 R8 R9 sweep", a, b, md[i % 10]);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_add();
    t_sub();
    t_overflow();
    t_bitwise();
    t_slt();
    t_unused();
    t_sweep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule